// File: doc/BRIEF.md
# Flash Read Prefetch Buffer Controller

This block sits between a 64-bit system-bus read port and a flash array whose read port returns one 128-bit line a fixed number of cycles after it is asked. Code-bank reads are served from four line buffers. A hit answers in the same cycle. A miss fetches the line from the array and keeps it in the least-recently-used buffer. After a code miss has been served, the block speculatively reads the next sequential line into a buffer, unless that line is already held.

Data-bank reads use a single 128-bit holding register and never prefetch. Word writes that are aligned go straight through to the array and drop any buffered copy of the line they touch. Requests the block cannot accept are answered at once with an error flag.

The bus master raises `bus_req` with the address, size, bank and direction, and holds them until `bus_ready` is high in a cycle. In that cycle `bus_rdata` and `bus_err` are valid.

Top module: `flash_prefetch_ctrl`

## Requirements
- R1: After reset every code buffer and the holding register are invalid, so the first read of any line is a miss. With `bus_req` low, `bus_ready`, `arr_req` and `arr_wr` are low.
- R2: The line index is `bus_addr[15:4]`. `bus_rdata` is bits [127:64] of the line when `bus_addr[3]` is 1, and bits [63:0] when it is 0.
- R3: A read that hits a valid buffer of its bank gets `bus_ready` in the same cycle the request is presented to an idle block (zero wait states).
- R4: A read miss raises `arr_req` with `arr_line` equal to the line index in the cycle it is taken. `bus_ready` follows after exactly three wait states, with the data the array returned.
- R5: A code miss fills the lowest-numbered invalid buffer. If no buffer is invalid, it fills the least recently used one. Every hit and every fill, including a prefetch fill, makes that buffer the most recent.
- R6: After a code-bank miss completes, the block requests line index + 1 (wrapping at 12 bits) in the next cycle, unless that line is already buffered. The block stays busy for four cycles after the demand completes.
- R7: A request presented while a prefetch is in flight waits until the prefetch has filled its buffer, and is then served as a hit or a miss.
- R8: `bus_size` is encoded as 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A read is accepted only when `bus_addr[1:0]` plus its byte count is at most 4. Any other read gets `bus_ready` and `bus_err` in the same cycle, with no array access.
- R9: Only word writes with `bus_addr[1:0]` = 0 are accepted. Such a write drives `arr_wr` with the bus address, data and bank in the same cycle and completes with no wait. Any other write gets `bus_err` and does not drive `arr_wr`.
- R10: An accepted write invalidates a code buffer holding that line (code bank) or the holding register holding it (data bank). The next read of that line is a miss.
- R11: Data-bank reads use one holding register. A hit has zero waits and a miss has three waits. A data-bank miss never starts a prefetch and leaves the code buffers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Request valid, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_bank | input | 1 | 0 = code bank, 1 = data bank |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_ready | output | 1 | Request completes this cycle |
| bus_err | output | 1 | Request rejected (valid with ready) |
| bus_rdata | output | 64 | Selected half of the line |
| arr_req | output | 1 | Array line read request |
| arr_bank | output | 1 | Bank for array read or write |
| arr_line | output | 12 | Line index to read |
| arr_rdata | input | 128 | Line data, valid three cycles after the request |
| arr_wr | output | 1 | Array write strobe |
| arr_waddr | output | 16 | Write address |
| arr_wdata | output | 64 | Write data |

## Verification
Hits, rejected requests and writes are due in the cycle they are presented. A miss is due three cycles after it is taken. A request that arrives while a prefetch is in flight is due four cycles after the previous miss completed, less any idle cycles in between, plus three more if it also misses. The bench keeps a model of buffer tags, recency order, the holding register and the remaining prefetch busy time. From that model it derives the exact number of wait cycles for every request. It then counts the cycles in which `bus_ready` is low, sampling on the falling clock edge, and compares that count and the returned data against the model.

// File: rtl/flash_pf_pkg.sv
package flash_pf_pkg;
    localparam int LINE_W = 128;
    localparam int BUS_W  = 64;
    localparam int OFS_W  = $clog2(LINE_W / 8);
    localparam int LSEL_W = $clog2(LINE_W / BUS_W);

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FILL     = 2'd1,
        ST_PF_ISSUE = 2'd2,
        ST_PF_WAIT  = 2'd3
    } pf_state_e;

    // read accepted only if it stays inside its 32-bit container
    function automatic logic rd_fits(input logic [1:0] size, input logic [1:0] off);
        case (size)
            2'd0:    return 1'b1;
            2'd1:    return off != 2'd3;
            2'd2:    return off == 2'd0;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/flash_pf_lru.sv
module flash_pf_lru #(
    parameter int NWAY = 4,
    localparam int WW  = $clog2(NWAY)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            touch_i,
    input  logic [WW-1:0]   touch_way_i,
    input  logic [NWAY-1:0] valid_i,
    output logic [WW-1:0]   victim_o
);
    logic [NWAY-1:0][WW-1:0] age_d, age_q;
    logic found;

    always_comb begin
        age_d = age_q;
        if (touch_i) begin
            for (int i = 0; i < NWAY; i++) begin
                if (age_q[i] < age_q[touch_way_i]) age_d[i] = age_q[i] + 1'b1;
            end
            age_d[touch_way_i] = '0;
        end
    end

    always_comb begin
        victim_o = '0;
        found    = 1'b0;
        for (int i = 0; i < NWAY; i++) begin
            if (!valid_i[i] && !found) begin
                victim_o = WW'(i);
                found    = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < NWAY; i++) begin
                if (age_q[i] == WW'(NWAY - 1)) victim_o = WW'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWAY; i++) age_q[i] <= WW'(i);
        end else begin
            age_q <= age_d;
        end
    end
endmodule

// File: rtl/flash_pf_lane.sv
module flash_pf_lane
    import flash_pf_pkg::*;
(
    input  logic [LINE_W-1:0] line_i,
    input  logic [LSEL_W-1:0] sel_i,
    output logic [BUS_W-1:0]  data_o
);
    always_comb data_o = line_i[sel_i * BUS_W +: BUS_W];
endmodule

// File: rtl/flash_prefetch_ctrl.sv
module flash_prefetch_ctrl
    import flash_pf_pkg::*;
#(
    parameter int AW          = 16,
    parameter int NBUF        = 4,
    parameter int WAIT_STATES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic                  bus_bank,
    input  logic [1:0]            bus_size,
    input  logic [AW-1:0]         bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic                  bus_ready,
    output logic                  bus_err,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  arr_req,
    output logic                  arr_bank,
    output logic [AW-OFS_W-1:0]   arr_line,
    input  logic [LINE_W-1:0]     arr_rdata,
    output logic                  arr_wr,
    output logic [AW-1:0]         arr_waddr,
    output logic [BUS_W-1:0]      arr_wdata
);
    localparam int TAG_W = AW - OFS_W;
    localparam int WW    = $clog2(NBUF);
    localparam int CW    = $clog2(WAIT_STATES + 1);

    typedef struct packed {
        pf_state_e                     st;
        logic [CW-1:0]                 cnt;
        logic [TAG_W-1:0]              ftag;
        logic                          fbank;
        logic [WW-1:0]                 fway;
        logic [NBUF-1:0]               bv;
        logic [NBUF-1:0][TAG_W-1:0]    btag;
        logic [NBUF-1:0][LINE_W-1:0]   bdat;
        logic                          hv;
        logic [TAG_W-1:0]              htag;
        logic [LINE_W-1:0]             hdat;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [TAG_W-1:0]  req_tag, nxt_tag;
    logic [NBUF-1:0]   hitv, nxtv, fway_oh;
    logic [WW-1:0]     hit_way, victim, touch_way;
    logic              touch, hold_hit, wr_ok, rd_ok, last_cnt, pf_issue;
    logic [LINE_W-1:0] line_sel;
    logic              unused_addr_bit;

    assign req_tag         = bus_addr[AW-1:OFS_W];
    assign nxt_tag         = s_q.ftag + 1'b1;
    assign hold_hit        = s_q.hv && (s_q.htag == req_tag);
    assign wr_ok           = (bus_size == 2'd2) && (bus_addr[1:0] == 2'd0);
    assign rd_ok           = rd_fits(bus_size, bus_addr[1:0]);
    assign last_cnt        = (s_q.cnt == CW'(WAIT_STATES));
    assign fway_oh         = NBUF'(1) << s_q.fway;
    assign unused_addr_bit = bus_addr[2];

    for (genvar g = 0; g < NBUF; g++) begin : g_cmp
        assign hitv[g] = s_q.bv[g] && (s_q.btag[g] == req_tag);
        assign nxtv[g] = s_q.bv[g] && (s_q.btag[g] == nxt_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < NBUF; i++) if (hitv[i]) hit_way = WW'(i);
    end

    flash_pf_lru #(.NWAY(NBUF)) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_i     (touch),
        .touch_way_i (touch_way),
        .valid_i     (s_q.bv),
        .victim_o    (victim)
    );

    flash_pf_lane u_lane (
        .line_i (line_sel),
        .sel_i  (bus_addr[3 +: LSEL_W]),
        .data_o (bus_rdata)
    );

    always_comb begin
        s_d       = s_q;
        bus_ready = 1'b0;
        bus_err   = 1'b0;
        arr_req   = 1'b0;
        arr_bank  = bus_bank;
        arr_line  = req_tag;
        arr_wr    = 1'b0;
        arr_waddr = bus_addr;
        arr_wdata = bus_wdata;
        line_sel  = s_q.hdat;
        touch     = 1'b0;
        touch_way = hit_way;
        pf_issue  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (bus_req) begin
                    if (bus_we) begin
                        bus_ready = 1'b1;
                        if (wr_ok) begin
                            arr_wr = 1'b1;
                            if (!bus_bank) s_d.bv = s_q.bv & ~hitv;
                            else if (hold_hit) s_d.hv = 1'b0;
                        end else begin
                            bus_err = 1'b1;
                        end
                    end else if (!rd_ok) begin
                        bus_ready = 1'b1;
                        bus_err   = 1'b1;
                    end else if (!bus_bank && |hitv) begin
                        bus_ready = 1'b1;
                        line_sel  = s_q.bdat[hit_way];
                        touch     = 1'b1;
                    end else if (bus_bank && hold_hit) begin
                        bus_ready = 1'b1;
                    end else begin
                        arr_req  = 1'b1;
                        s_d.st    = ST_FILL;
                        s_d.cnt   = CW'(1);
                        s_d.ftag  = req_tag;
                        s_d.fbank = bus_bank;
                        s_d.fway  = victim;
                    end
                end
            end
            ST_FILL: begin
                if (last_cnt) begin
                    bus_ready = 1'b1;
                    line_sel  = arr_rdata;
                    if (!s_q.fbank) begin
                        s_d.bdat[s_q.fway] = arr_rdata;
                        s_d.btag[s_q.fway] = s_q.ftag;
                        s_d.bv[s_q.fway]   = 1'b1;
                        touch     = 1'b1;
                        touch_way = s_q.fway;
                        s_d.st    = |(nxtv & ~fway_oh) ? ST_IDLE : ST_PF_ISSUE;
                    end else begin
                        s_d.hdat = arr_rdata;
                        s_d.htag = s_q.ftag;
                        s_d.hv   = 1'b1;
                        s_d.st   = ST_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_PF_ISSUE: begin
                pf_issue = 1'b1;
                arr_req  = 1'b1;
                arr_bank = 1'b0;
                arr_line = nxt_tag;
                s_d.ftag = nxt_tag;
                s_d.fway = victim;
                s_d.cnt  = CW'(1);
                s_d.st   = ST_PF_WAIT;
            end
            ST_PF_WAIT: begin
                if (last_cnt) begin
                    s_d.bdat[s_q.fway] = arr_rdata;
                    s_d.btag[s_q.fway] = s_q.ftag;
                    s_d.bv[s_q.fway]   = 1'b1;
                    touch     = 1'b1;
                    touch_way = s_q.fway;
                    s_d.st    = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/flash_pf_chk.sv
module flash_pf_chk #(
    parameter int WAIT_STATES = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_we,
    input logic [1:0] bus_lo,
    input logic       bus_ready,
    input logic       bus_err,
    input logic       arr_req,
    input logic       arr_bank,
    input logic       arr_wr,
    input logic       pf_issue
);
    logic [31:0] dem_cnt;
    logic        dem_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dem_cnt <= '0;
            dem_act <= 1'b0;
        end else if (arr_req && !pf_issue) begin
            dem_cnt <= 32'd1;
            dem_act <= 1'b1;
        end else if (dem_act) begin
            if (dem_cnt == 32'(WAIT_STATES)) dem_act <= 1'b0;
            else dem_cnt <= dem_cnt + 32'd1;
        end
    end

    p_ready_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> bus_req);
    p_no_ready_on_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && !pf_issue) |-> !bus_ready);
    p_miss_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_act && dem_cnt < 32'(WAIT_STATES)) |-> !bus_ready);
    p_miss_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_act && dem_cnt == 32'(WAIT_STATES)) |-> bus_ready);
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_ready && !arr_wr && !arr_req));
    p_write_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |-> (bus_we && bus_ready && !bus_err && bus_lo == 2'd0));
    p_pf_code_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pf_issue |-> (arr_req && !arr_bank));
    p_pf_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_issue |-> ($past(bus_ready) && !bus_ready));
endmodule

bind flash_prefetch_ctrl flash_pf_chk #(.WAIT_STATES(WAIT_STATES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_lo    (bus_addr[1:0]),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .arr_req   (arr_req),
    .arr_bank  (arr_bank),
    .arr_wr    (arr_wr),
    .pf_issue  (pf_issue)
);

// File: tb/flash_prefetch_ctrl_tb.sv
module flash_prefetch_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WS = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0, bus_we = 1'b0, bus_bank = 1'b0;
    logic [1:0]   bus_size = 2'd0;
    logic [15:0]  bus_addr = '0;
    logic [63:0]  bus_wdata = '0;
    logic         bus_ready, bus_err, arr_req, arr_bank, arr_wr;
    logic [63:0]  bus_rdata, arr_wdata;
    logic [11:0]  arr_line;
    logic [15:0]  arr_waddr;
    logic [127:0] arr_rdata;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prefetch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_bank(bus_bank), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .arr_req(arr_req), .arr_bank(arr_bank),
        .arr_line(arr_line), .arr_rdata(arr_rdata), .arr_wr(arr_wr),
        .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
    );

    function automatic logic [63:0] half_val(input logic b, input logic [11:0] l, input logic h);
        return {(b ? 8'hD0 : 8'hC0), 7'd0, h, 4'h0, l, 32'h600D_0000 ^ {20'd0, l}};
    endfunction

    // fixed-latency array model
    logic [WS-1:0]        pv = '0;
    logic [WS-1:0]        pb = '0;
    logic [WS-1:0][11:0]  pl = '0;
    always @(posedge clk) begin
        for (int i = WS - 1; i > 0; i--) begin
            pv[i] <= pv[i-1]; pb[i] <= pb[i-1]; pl[i] <= pl[i-1];
        end
        pv[0] <= arr_req; pb[0] <= arr_bank; pl[0] <= arr_line;
    end
    assign arr_rdata = pv[WS-1] ? {half_val(pb[WS-1], pl[WS-1], 1'b1), half_val(pb[WS-1], pl[WS-1], 1'b0)}
                                : '0;

    // reference model
    logic        m_v[4];
    logic [11:0] m_t[4];
    int          order[4];
    logic        h_v;
    logic [11:0] h_t;
    int          pf_left;

    function automatic int m_find(input logic [11:0] t);
        for (int i = 0; i < 4; i++) if (m_v[i] && m_t[i] == t) return i;
        return -1;
    endfunction

    task automatic m_touch(input int w);
        int p;
        p = 0;
        for (int i = 0; i < 4; i++) if (order[i] == w) p = i;
        for (int i = p; i > 0; i--) order[i] = order[i-1];
        order[0] = w;
    endtask

    function automatic int m_victim();
        for (int i = 0; i < 4; i++) if (!m_v[i]) return i;
        return order[3];
    endfunction

    task automatic m_fill(input logic [11:0] t);
        int v;
        v = m_victim();
        m_v[v] = 1'b1; m_t[v] = t;
        m_touch(v);
    endtask

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input string tag, input int gap, input logic we, input logic bank,
                         input logic [1:0] size, input logic [15:0] addr, input logic [63:0] wd);
        int waits, exp_w, nb, w;
        logic exp_err, fits;
        logic [11:0] t;
        logic [63:0] got_d;
        logic got_err, got_wr;
        logic [15:0] got_wa;
        logic [63:0] got_wd;
        t = addr[15:4];
        if (gap > 0) begin
            bus_req = 1'b0;
            repeat (gap) begin @(posedge clk); #1; end
        end
        pf_left = (pf_left > gap) ? pf_left - gap : 0;
        exp_w = pf_left;
        pf_left = 0;
        nb = (size == 2'd3) ? 0 : (1 << size);
        fits = (nb != 0) && (int'(addr[1:0]) + nb <= 4);
        exp_err = 1'b0;
        if (we) begin
            exp_err = !(size == 2'd2 && addr[1:0] == 2'd0);
            if (!exp_err) begin
                if (!bank) begin
                    w = m_find(t);
                    if (w >= 0) m_v[w] = 1'b0;
                end else if (h_v && h_t == t) h_v = 1'b0;
            end
        end else if (!fits) begin
            exp_err = 1'b1;
        end else if (!bank) begin
            w = m_find(t);
            if (w >= 0) m_touch(w);
            else begin
                exp_w += WS;
                m_fill(t);
                if (m_find(t + 12'd1) < 0) begin
                    m_fill(t + 12'd1);
                    pf_left = WS + 1;
                end
            end
        end else if (!(h_v && h_t == t)) begin
            exp_w += WS;
            h_v = 1'b1; h_t = t;
        end
        bus_req = 1'b1; bus_we = we; bus_bank = bank; bus_size = size;
        bus_addr = addr; bus_wdata = wd;
        waits = 0;
        forever begin
            @(negedge clk);
            if (bus_ready || waits > 40) break;
            waits++;
        end
        got_d = bus_rdata; got_err = bus_err; got_wr = arr_wr;
        got_wa = arr_waddr; got_wd = arr_wdata;
        chk(waits == exp_w, tag, "wait states", 64'(waits), 64'(exp_w));
        chk(got_err == exp_err, we ? "R9" : "R8", "error flag", 64'(got_err), 64'(exp_err));
        if (we) begin
            chk(got_wr == !exp_err, "R9", "write strobe", 64'(got_wr), 64'(!exp_err));
            if (!exp_err) begin
                chk(got_wa == addr, "R9", "write address", 64'(got_wa), 64'(addr));
                chk(got_wd == wd, "R9", "write data", got_wd, wd);
            end
        end else if (!exp_err) begin
            chk(got_d == half_val(bank, t, addr[3]), "R2", "read data", got_d, half_val(bank, t, addr[3]));
        end
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 4; i++) begin m_v[i] = 1'b0; m_t[i] = '0; order[i] = i; end
        h_v = 1'b0; h_t = '0; pf_left = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(bus_ready == 1'b0, "R1", "ready idle", 64'(bus_ready), 64'd0);
        chk(arr_req == 1'b0, "R1", "arr_req idle", 64'(arr_req), 64'd0);
        chk(arr_wr == 1'b0, "R1", "arr_wr idle", 64'(arr_wr), 64'd0);
        @(posedge clk); #1;
        do_op("R1", 0, 0, 0, 2'd2, 16'h0050, '0);        // first read misses
        do_op("R6", 0, 0, 0, 2'd2, 16'h0068, '0);        // prefetched next line
        do_op("R3", 0, 0, 0, 2'd2, 16'h0058, '0);        // hit, upper half
        // R8: read size/offset sweep on a hit line
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                do_op("R8", 0, 0, 0, 2'(s), 16'h0050 | 16'(o), '0);
        // R9: write sweep, R10: aligned write invalidates
        for (int s = 0; s < 4; s++)
            for (int o = 3; o >= 0; o--)
                do_op("R9", 0, 1, 0, 2'(s), 16'h0050 | 16'(o), 64'hFEED_0000_0000_0000 | 64'(s * 4 + o));
        do_op("R10", 0, 0, 0, 2'd2, 16'h0050, '0);
        // R11: data bank holding register
        do_op("R11", 1, 0, 1, 2'd2, 16'h0030, '0);
        do_op("R11", 0, 0, 1, 2'd0, 16'h003B, '0);
        do_op("R11", 0, 0, 1, 2'd2, 16'h0040, '0);
        do_op("R11", 0, 0, 0, 2'd2, 16'h0068, '0);
        do_op("R10", 0, 1, 1, 2'd2, 16'h0040, 64'h1234);
        do_op("R10", 0, 0, 1, 2'd2, 16'h0040, '0);
        // R6: wrap of the next line index
        do_op("R6", 2, 0, 0, 2'd2, 16'hFFF0, '0);
        do_op("R6", 0, 0, 0, 2'd2, 16'h0008, '0);
        // R6: no prefetch when next line is held
        do_op("R6", 5, 0, 0, 2'd2, 16'h1010, '0);
        do_op("R6", 5, 0, 0, 2'd2, 16'h1000, '0);
        do_op("R6", 0, 0, 0, 2'd2, 16'h3000, '0);
        // R7: request during prefetch
        do_op("R7", 6, 0, 0, 2'd2, 16'h4000, '0);
        do_op("R7", 2, 0, 0, 2'd2, 16'h5000, '0);
        do_op("R7", 1, 1, 0, 2'd2, 16'h5010, 64'h55);
        // R5: replacement sweep over a small line set
        lf = 16'hACE1;
        for (int k = 0; k < 500; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[15:13] == 3'd0)
                do_op("R5", int'(lf[1:0]), 1, lf[12], 2'd2, {9'd0, lf[6:4], 4'd0}, 64'(lf));
            else
                do_op("R5", int'(lf[1:0]), 0, lf[12] & lf[11], lf[9:8], {9'd0, lf[6:4], lf[3:0]}, '0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule